// File: doc/BRIEF.md
# Beam-Synchronised Display List Engine

This block runs a small program of two-word instructions in step with the raster beam. It reads each instruction from memory one word at a time, using only the DMA slots that the surrounding arbiter grants to it. There are three kinds of instruction:

- A register-load instruction, which writes a 16-bit value to one custom register.
- A wait instruction, which holds the engine until the beam reaches a masked position.
- A conditional skip, which steps over the following instruction if the beam has already reached a masked position.

Two list base addresses are held outside the block. Each frame start restarts the engine from the first one. Either base can also be entered through an external go strobe, or through a register-load instruction aimed at the matching strobe index. A register-load instruction aimed at a protected index is refused, and the engine halts with an error until the next frame. A wait for a position the beam never reaches parks the engine until the next restart.

Top module: `dlist_engine`

## Requirements
- R1: While reset is high and after it is released, the engine requests no slot, reads nothing, writes nothing and shows no error until a frame start or a go strobe arrives.
- R2: A read happens only in a cycle where `slot` is high and the engine is requesting. The first word of an instruction comes from the program counter and the second word from the next word address, on the next granted slot. After a restart, the first read takes the first granted slot.
- R3: An instruction whose first word has bit 0 clear is a register load. Bits 8:1 of the first word give the register index, and the second word is the data. If the load is legal, `wr_en` pulses for one cycle in the cycle after the second word is read, carrying that index and data.
- R4: An instruction whose first word has bit 0 set and whose second word has bit 0 clear is a wait. Its target is vertical = first word bits 15:8 and horizontal = first word bits 7:1. Its masks are vertical = {1, second word bits 14:8} and horizontal = second word bits 7:1. The engine stops fetching until {vpos & vmask, hpos[7:1] & hmask} is greater than or equal to {target & masks}, then reads the next first word on the first granted slot after the cycle in which that first holds.
- R5: A wait whose position has already been reached resumes fetching on the first granted slot after the instruction completes, with no extra idle line.
- R6: When the second word has bit 0 set, the instruction is a skip. If the masked position compares as reached when its second word is read, the following instruction is neither read nor executed. Otherwise execution continues with the following instruction.
- R7: A register load to index 0x44 reloads the program counter from the first list base, and one to index 0x45 from the second list base; neither produces a register write. A one-cycle `list1_go` or `list2_go` pulse does the same. A frame start outranks a go pulse.
- R8: A register load to any index below 0x20 produces no write, sets `err` and halts fetching. While `err` is set, the go strobes are ignored.
- R9: A frame start clears `err` and reloads the program counter from the first list base, so that fetching resumes from it.
- R10: While `enable` is low, the engine neither requests slots nor reads.
- R11: A wait for vertical 0xFF and horizontal 0x7F with full masks never matches within the beam range. After it, no reads happen until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Coprocessor DMA enable bit |
| frame_start | input | 1 | One-cycle pulse at the start of each frame |
| list1_go | input | 1 | Strobe: jump to the first list base |
| list2_go | input | 1 | Strobe: jump to the second list base |
| list1_base | input | AW | First list location (byte address) |
| list2_base | input | AW | Second list location (byte address) |
| vpos | input | VW | Current beam line |
| hpos | input | HW | Current beam horizontal position |
| slot | input | 1 | A memory slot is granted to the engine this cycle |
| dma_req | output | 1 | The engine wants a slot |
| rd_en | output | 1 | Instruction word read in this cycle |
| rd_addr | output | AW | Byte address of the word being read |
| rd_data | input | 16 | Instruction word returned in the same cycle |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | 8 | Register index of the write |
| wr_data | output | 16 | Data of the write |
| err | output | 1 | Illegal register load seen since the last frame start |

## Verification
The bench builds the block with AW = 12 and 8-bit beam counters. It drives a short beam of 32 positions by 12 lines and grants slots on odd positions, so every wait target, including one that can never be reached, lies within a few hundred cycles. This timing allows exact checks of the fetch position at which a vertical wait resumes and of the position at which a horizontal wait with vertical masking resumes. The small address width lets several independent lists, together with both list bases, sit in one small bench memory.

// File: rtl/dlist_pkg.sv
package dlist_pkg;

    localparam int WORD_W = 16;
    localparam int IDX_W  = 8;
    localparam int VFLD_W = 8;
    localparam int HFLD_W = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_FETCH1 = 2'd1,
        ST_FETCH2 = 2'd2,
        ST_WAIT   = 2'd3
    } eng_state_t;

    typedef enum logic [1:0] {
        OP_MOVE = 2'd0,
        OP_WAIT = 2'd1,
        OP_SKIP = 2'd2
    } op_kind_t;

    typedef struct packed {
        logic [VFLD_W-1:0] v;
        logic [HFLD_W-1:0] h;
        logic [VFLD_W-1:0] vmask;
        logic [HFLD_W-1:0] hmask;
    } beam_tgt_t;

    typedef struct packed {
        op_kind_t          kind;
        logic [IDX_W-1:0]  idx;
        logic              illegal;
        logic              hit_list1;
        logic              hit_list2;
        word_t             data;
        beam_tgt_t         tgt;
    } op_t;

    function automatic beam_tgt_t target_of(word_t w1, word_t w2);
        beam_tgt_t t;
        t.v     = w1[15:8];
        t.h     = w1[7:1];
        t.vmask = {1'b1, w2[14:8]};
        t.hmask = w2[7:1];
        return t;
    endfunction

    function automatic op_kind_t kind_of(word_t w1, word_t w2);
        if (!w1[0])
            return OP_MOVE;
        else if (w2[0])
            return OP_SKIP;
        else
            return OP_WAIT;
    endfunction

endpackage

// File: rtl/dlist_decode.sv
module dlist_decode
    import dlist_pkg::*;
#(
    parameter logic [IDX_W-1:0] PROT_IDX  = 8'h20,
    parameter logic [IDX_W-1:0] LIST1_IDX = 8'h44,
    parameter logic [IDX_W-1:0] LIST2_IDX = 8'h45
) (
    input  word_t w1,
    input  word_t w2,
    output op_t   op
);

    logic is_move;
    logic [IDX_W-1:0] reg_idx;
    logic below_prot;

    always_comb begin
        is_move    = (kind_of(w1, w2) == OP_MOVE);
        reg_idx    = w1[IDX_W:1];
        below_prot = (reg_idx < PROT_IDX);

        op.kind      = kind_of(w1, w2);
        op.idx       = reg_idx;
        op.illegal   = is_move && below_prot;
        op.hit_list1 = is_move && !below_prot && (reg_idx == LIST1_IDX);
        op.hit_list2 = is_move && !below_prot && (reg_idx == LIST2_IDX);
        op.data      = w2;
        op.tgt       = target_of(w1, w2);
    end

endmodule

// File: rtl/dlist_beam_cmp.sv
module dlist_beam_cmp
    import dlist_pkg::*;
#(
    parameter int VW = 8,
    parameter int HW = 8
) (
    input  logic [VW-1:0] vpos,
    input  logic [HW-1:0] hpos,
    input  beam_tgt_t     tgt,
    output logic          reached
);

    localparam int CMP_W = VFLD_W + HFLD_W + 1;

    logic [VFLD_W-1:0] cur_v;
    logic [HFLD_W-1:0] cur_h;
    logic [CMP_W-1:0]  beam_m;
    logic [CMP_W-1:0]  tgt_m;

    genvar i;
    generate
        for (i = 0; i < VFLD_W; i++) begin : g_vbit
            if (i < VW) begin : g_have
                assign cur_v[i] = vpos[i];
            end else begin : g_pad
                assign cur_v[i] = 1'b0;
            end
        end
        for (i = 0; i < HFLD_W; i++) begin : g_hbit
            if (i + 1 < HW) begin : g_have
                assign cur_h[i] = hpos[i+1];
            end else begin : g_pad
                assign cur_h[i] = 1'b0;
            end
        end
        for (i = 0; i < VFLD_W; i++) begin : g_vmask
            assign beam_m[CMP_W-VFLD_W+i] = cur_v[i] & tgt.vmask[i];
            assign tgt_m[CMP_W-VFLD_W+i]  = tgt.v[i] & tgt.vmask[i];
        end
        for (i = 0; i < HFLD_W; i++) begin : g_hmask
            assign beam_m[i+1] = cur_h[i] & tgt.hmask[i];
            assign tgt_m[i+1]  = tgt.h[i] & tgt.hmask[i];
        end
    endgenerate

    // The lowest position bit only ever makes the beam larger or equal.
    assign beam_m[0] = hpos[0];
    assign tgt_m[0]  = 1'b0;

    assign reached = (beam_m >= tgt_m);

endmodule

// File: rtl/dlist_pc.sv
module dlist_pc #(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          adv,
    input  logic          adv_skip,
    output logic [AW-1:0] pc
);

    localparam logic [AW-1:0] STEP_WORD = AW'(2);
    localparam logic [AW-1:0] STEP_SKIP = AW'(6);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= '0;
        else if (load)
            pc <= load_val;
        else if (adv)
            pc <= pc + (adv_skip ? STEP_SKIP : STEP_WORD);
    end

endmodule

// File: rtl/dlist_engine.sv
module dlist_engine
    import dlist_pkg::*;
#(
    parameter int AW = 20,
    parameter int VW = 8,
    parameter int HW = 8,
    parameter logic [IDX_W-1:0] PROT_IDX  = 8'h20,
    parameter logic [IDX_W-1:0] LIST1_IDX = 8'h44,
    parameter logic [IDX_W-1:0] LIST2_IDX = 8'h45
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             frame_start,
    input  logic             list1_go,
    input  logic             list2_go,
    input  logic [AW-1:0]    list1_base,
    input  logic [AW-1:0]    list2_base,
    input  logic [VW-1:0]    vpos,
    input  logic [HW-1:0]    hpos,
    input  logic             slot,
    output logic             dma_req,
    output logic             rd_en,
    output logic [AW-1:0]    rd_addr,
    input  logic [15:0]      rd_data,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [15:0]      wr_data,
    output logic             err
);

    eng_state_t state_q, state_d;
    word_t      w1_q, w2_q, w2_now;
    op_t        op;
    logic       reached;
    logic       fetching, exec, ext_go, skip_taken, list_jump;
    logic       pc_load;
    logic [AW-1:0] pc_load_val, pc;
    logic       err_q;
    logic       wr_en_q;
    logic [IDX_W-1:0] wr_idx_q;
    word_t      wr_data_q;

    assign fetching = (state_q == ST_FETCH1) || (state_q == ST_FETCH2);
    assign dma_req  = enable && fetching;
    assign rd_en    = dma_req && slot;
    assign rd_addr  = pc;
    assign exec     = rd_en && (state_q == ST_FETCH2);
    assign w2_now   = (state_q == ST_FETCH2) ? rd_data : w2_q;

    dlist_decode #(
        .PROT_IDX (PROT_IDX),
        .LIST1_IDX(LIST1_IDX),
        .LIST2_IDX(LIST2_IDX)
    ) u_dec (
        .w1(w1_q),
        .w2(w2_now),
        .op(op)
    );

    dlist_beam_cmp #(
        .VW(VW),
        .HW(HW)
    ) u_cmp (
        .vpos   (vpos),
        .hpos   (hpos),
        .tgt    (op.tgt),
        .reached(reached)
    );

    assign ext_go     = (list1_go || list2_go) && !err_q;
    assign skip_taken = exec && (op.kind == OP_SKIP) && reached;
    assign list_jump  = exec && (op.hit_list1 || op.hit_list2);
    assign pc_load    = frame_start || ext_go || list_jump;

    always_comb begin
        if (frame_start || (ext_go && list1_go))
            pc_load_val = list1_base;
        else if (ext_go)
            pc_load_val = list2_base;
        else if (op.hit_list1)
            pc_load_val = list1_base;
        else
            pc_load_val = list2_base;
    end

    dlist_pc #(
        .AW(AW)
    ) u_pc (
        .clk     (clk),
        .rst     (rst),
        .load    (pc_load),
        .load_val(pc_load_val),
        .adv     (rd_en),
        .adv_skip(skip_taken),
        .pc      (pc)
    );

    always_comb begin
        state_d = state_q;
        if (frame_start || ext_go) begin
            state_d = ST_FETCH1;
        end else begin
            unique case (state_q)
                ST_FETCH1: if (rd_en) state_d = ST_FETCH2;
                ST_FETCH2: begin
                    if (rd_en) begin
                        if (op.illegal)
                            state_d = ST_HALT;
                        else if (op.kind == OP_WAIT)
                            state_d = ST_WAIT;
                        else
                            state_d = ST_FETCH1;
                    end
                end
                ST_WAIT:   if (reached) state_d = ST_FETCH1;
                ST_HALT:   state_d = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_HALT;
            w1_q      <= '0;
            w2_q      <= '0;
            err_q     <= 1'b0;
            wr_en_q   <= 1'b0;
            wr_idx_q  <= '0;
            wr_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (rd_en && (state_q == ST_FETCH1))
                w1_q <= rd_data;
            if (exec)
                w2_q <= rd_data;

            if (frame_start)
                err_q <= 1'b0;
            else if (exec && op.illegal)
                err_q <= 1'b1;

            wr_en_q <= exec && !frame_start && !ext_go &&
                       (op.kind == OP_MOVE) && !op.illegal &&
                       !op.hit_list1 && !op.hit_list2;
            if (exec) begin
                wr_idx_q  <= op.idx;
                wr_data_q <= op.data;
            end
        end
    end

    assign wr_en   = wr_en_q;
    assign wr_idx  = wr_idx_q;
    assign wr_data = wr_data_q;
    assign err     = err_q;

endmodule

// File: rtl/dlist_engine_chk.sv
module dlist_engine_chk
    import dlist_pkg::*;
#(
    parameter logic [IDX_W-1:0] PROT_IDX  = 8'h20,
    parameter logic [IDX_W-1:0] LIST1_IDX = 8'h44,
    parameter logic [IDX_W-1:0] LIST2_IDX = 8'h45
) (
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic             frame_start,
    input logic             slot,
    input logic             dma_req,
    input logic             rd_en,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx,
    input logic             err
);

    AST_READ_NEEDS_SLOT: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (slot && dma_req)); // R2

    AST_OFF_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        !enable |-> (!dma_req && !rd_en)); // R10

    AST_WR_NOT_PROTECTED: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx >= PROT_IDX)); // R8

    AST_ERR_STOPS_FETCH: assert property (@(posedge clk) disable iff (rst)
        err |-> !dma_req); // R8

    AST_WR_NOT_STROBE: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_idx != LIST1_IDX && wr_idx != LIST2_IDX)); // R7

    AST_RESTART_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !err); // R9

    AST_RESTART_REQUESTS: assert property (@(posedge clk) disable iff (rst)
        ($past(frame_start) && enable) |-> dma_req); // R9

endmodule

bind dlist_engine dlist_engine_chk #(
    .PROT_IDX (PROT_IDX),
    .LIST1_IDX(LIST1_IDX),
    .LIST2_IDX(LIST2_IDX)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .frame_start(frame_start),
    .slot       (slot),
    .dma_req    (dma_req),
    .rd_en      (rd_en),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .err        (err)
);

// File: tb/dlist_engine_test.sv
module dlist_engine_test;

    localparam int AW   = 12;
    localparam int HMAX = 32;
    localparam int VMAX = 12;
    localparam int LOGN = 512;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b1;
    logic frame_start = 1'b0;
    logic list1_go = 1'b0;
    logic list2_go = 1'b0;
    logic [AW-1:0] list1_base = '0;
    logic [AW-1:0] list2_base = '0;
    logic [7:0] vpos = '0;
    logic [7:0] hpos = '0;
    logic slot;
    logic dma_req, rd_en, wr_en, err;
    logic [AW-1:0] rd_addr;
    logic [15:0] rd_data, wr_data;
    logic [7:0] wr_idx;

    logic [15:0] mem [0:255];

    int vectors = 0;
    int fails = 0;
    int cyc = 0;

    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [AW-1:0] rd_a [0:LOGN-1];
    logic [7:0]    rd_h [0:LOGN-1];
    logic [7:0]    rd_v [0:LOGN-1];
    logic [7:0]    wr_i [0:LOGN-1];
    logic [15:0]   wr_d [0:LOGN-1];
    logic [7:0]    wr_h [0:LOGN-1];

    always #4 clk = ~clk;

    assign slot    = hpos[0];
    assign rd_data = mem[rd_addr[8:1]];

    dlist_engine #(.AW(AW), .VW(8), .HW(8)) uut (
        .clk(clk), .rst(rst), .enable(enable), .frame_start(frame_start),
        .list1_go(list1_go), .list2_go(list2_go),
        .list1_base(list1_base), .list2_base(list2_base),
        .vpos(vpos), .hpos(hpos), .slot(slot), .dma_req(dma_req),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .err(err)
    );

    always @(posedge clk) begin
        if (rst) begin
            hpos <= '0;
            vpos <= '0;
        end else if (hpos == HMAX - 1) begin
            hpos <= '0;
            vpos <= (vpos == VMAX - 1) ? 8'd0 : vpos + 8'd1;
        end else begin
            hpos <= hpos + 8'd1;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (rd_en && rd_cnt < LOGN) begin
                rd_a[rd_cnt] = rd_addr;
                rd_h[rd_cnt] = hpos;
                rd_v[rd_cnt] = vpos;
                rd_cnt = rd_cnt + 1;
            end
            if (wr_en && wr_cnt < LOGN) begin
                wr_i[wr_cnt] = wr_idx;
                wr_d[wr_cnt] = wr_data;
                wr_h[wr_cnt] = hpos;
                wr_cnt = wr_cnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", vectors + 1, fails + 1);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        repeat (n) tick();
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [15:0] w);
        mem[addr >> 1] = w;
    endtask

    task automatic put_move(input int addr, input logic [7:0] idx, input logic [15:0] d);
        put(addr, {7'b0, idx, 1'b0});
        put(addr + 2, d);
    endtask

    task automatic put_park(input int addr);
        put(addr, 16'hFFFF);
        put(addr + 2, 16'hFFFE);
    endtask

    task automatic restart();
        do tick(); while (!(hpos == 8'd0 && vpos == 8'd0));
        frame_start = 1'b1;
        tick();
        frame_start = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dma_req in reset", dma_req, 0);
        check("R1 wr_en in reset", wr_en, 0);
        rst = 1'b0;
        run(40);
        check("R1 no reads after reset", rd_cnt, 0);
        check("R1 no writes after reset", wr_cnt, 0);
        check("R1 err after reset", err, 0);
    endtask

    task automatic t_move();
        int rb, wb;
        list1_base = 12'h000;
        put_move(12'h000, 8'h30, 16'h1234);
        put_move(12'h004, 8'h31, 16'hABCD);
        put_park(12'h008);
        rb = rd_cnt; wb = wr_cnt;
        restart();
        run(64);
        check("R2 read count", rd_cnt - rb, 6);
        for (int k = 0; k < 6; k++)
            check("R2 read address", rd_a[rb+k], k * 2);
        check("R2 first read slot", rd_h[rb], 1);
        check("R2 sixth read slot", rd_h[rb+5], 11);
        check("R3 write count", wr_cnt - wb, 2);
        check("R3 first index", wr_i[wb], 8'h30);
        check("R3 first data", wr_d[wb], 16'h1234);
        check("R3 first write position", wr_h[wb], 4);
        check("R3 second index", wr_i[wb+1], 8'h31);
        check("R3 second data", wr_d[wb+1], 16'hABCD);
        run(HMAX * VMAX);
        check("R11 parked no reads", rd_cnt - rb, 6);
    endtask

    task automatic t_vwait();
        int rb, wb;
        list1_base = 12'h020;
        put(12'h020, 16'h0301);
        put(12'h022, 16'hFFFE);
        put_move(12'h024, 8'h50, 16'h0055);
        put_park(12'h028);
        rb = rd_cnt; wb = wr_cnt;
        restart();
        do tick(); while (vpos != 8'd4);
        check("R4 vwait resume address", rd_a[rb+2], 12'h024);
        check("R4 vwait resume line", rd_v[rb+2], 3);
        check("R4 vwait resume position", rd_h[rb+2], 1);
        check("R4 vwait write", wr_d[wb], 16'h0055);
    endtask

    task automatic t_hwait();
        int rb;
        list1_base = 12'h040;
        put(12'h040, 16'h0515);
        put(12'h042, 16'h00FE);
        put_move(12'h044, 8'h51, 16'h0066);
        put_park(12'h048);
        rb = rd_cnt;
        restart();
        run(64);
        check("R4 masked wait address", rd_a[rb+2], 12'h044);
        check("R4 masked wait line", rd_v[rb+2], 0);
        check("R4 masked wait position", rd_h[rb+2], 21);
    endtask

    task automatic t_wait_done();
        int rb;
        list1_base = 12'h060;
        put(12'h060, 16'h0001);
        put(12'h062, 16'hFFFE);
        put_move(12'h064, 8'h52, 16'h0077);
        put_park(12'h068);
        rb = rd_cnt;
        restart();
        run(64);
        check("R5 reached wait address", rd_a[rb+2], 12'h064);
        check("R5 reached wait position", rd_h[rb+2], 5);
        check("R5 reached wait line", rd_v[rb+2], 0);
    endtask

    task automatic t_skip();
        int wb;
        list1_base = 12'h080;
        put(12'h080, 16'h0001);
        put(12'h082, 16'hFFFF);
        put_move(12'h084, 8'h53, 16'h0001);
        put_move(12'h088, 8'h54, 16'h0002);
        put_park(12'h08C);
        wb = wr_cnt;
        restart();
        run(64);
        check("R6 taken skip write count", wr_cnt - wb, 1);
        check("R6 taken skip index", wr_i[wb], 8'h54);
        check("R6 taken skip data", wr_d[wb], 16'h0002);

        list1_base = 12'h0A0;
        put(12'h0A0, 16'hFF01);
        put(12'h0A2, 16'hFFFF);
        put_move(12'h0A4, 8'h53, 16'h0003);
        put_move(12'h0A8, 8'h54, 16'h0004);
        put_park(12'h0AC);
        wb = wr_cnt;
        restart();
        run(64);
        check("R6 untaken skip write count", wr_cnt - wb, 2);
        check("R6 untaken skip first index", wr_i[wb], 8'h53);
        check("R6 untaken skip second index", wr_i[wb+1], 8'h54);
    endtask

    task automatic t_lists();
        int rb, wb;
        list1_base = 12'h0C0;
        list2_base = 12'h0E0;
        put_move(12'h0C0, 8'h45, 16'h0000);
        put_move(12'h0C4, 8'h60, 16'h0009);
        put_move(12'h0E0, 8'h61, 16'h0007);
        put_park(12'h0E4);
        rb = rd_cnt; wb = wr_cnt;
        restart();
        run(64);
        check("R7 strobe jump address", rd_a[rb+2], 12'h0E0);
        check("R7 strobe write count", wr_cnt - wb, 1);
        check("R7 second list write", wr_i[wb], 8'h61);

        list1_base = 12'h100;
        put_move(12'h100, 8'h62, 16'h0088);
        put_park(12'h104);
        wb = wr_cnt;
        list1_go = 1'b1;
        tick();
        list1_go = 1'b0;
        run(20);
        check("R7 go strobe write count", wr_cnt - wb, 1);
        check("R7 go strobe data", wr_d[wb], 16'h0088);
    endtask

    task automatic t_illegal();
        int rb, wb;
        list1_base = 12'h120;
        put_move(12'h120, 8'h10, 16'h0005);
        put_move(12'h124, 8'h62, 16'h0001);
        rb = rd_cnt; wb = wr_cnt;
        restart();
        run(40);
        check("R8 illegal no write", wr_cnt - wb, 0);
        check("R8 illegal err", err, 1);
        check("R8 illegal halt reads", rd_cnt - rb, 2);
        check("R8 illegal no request", dma_req, 0);
        list1_go = 1'b1;
        tick();
        list1_go = 1'b0;
        run(20);
        check("R8 go ignored during error", rd_cnt - rb, 2);
    endtask

    task automatic t_restart();
        int wb;
        list1_base = 12'h000;
        wb = wr_cnt;
        restart();
        check("R9 err cleared", err, 0);
        run(64);
        check("R9 reload write count", wr_cnt - wb, 2);
        check("R9 reload data", wr_d[wb], 16'h1234);
    endtask

    task automatic t_enable();
        int rb;
        enable = 1'b0;
        rb = rd_cnt;
        restart();
        run(40);
        check("R10 disabled reads", rd_cnt - rb, 0);
        check("R10 disabled request", dma_req, 0);
        enable = 1'b1;
        run(40);
        check("R10 enabled resumes", (rd_cnt > rb) ? 1 : 0, 1);
        check("R10 enabled first address", rd_a[rb], 12'h000);
    endtask

    initial begin
        for (int k = 0; k < 256; k++) mem[k] = 16'hFFFF;
        run(5);
        t_reset();
        t_move();
        t_vwait();
        t_hwait();
        t_wait_done();
        t_skip();
        t_lists();
        t_illegal();
        t_restart();
        t_enable();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule